// File: doc/BRIEF.md
# Three-Output Clock Source Selector and Post-Divider

This block turns two free-running PLL outputs and a board reference into three divided clock enables: one for the processor, one for the memory controller and one for the on-chip bus. Every clock source arrives as a one-cycle tick strobe sampled in a fast system clock `clk`, and every output is a one-cycle tick strobe in the same domain. The rate of an output is the rate of its ticks. The analog PLLs are outside the block and appear only as these strobes.

A single 32-bit control word, written and read through a plain write-enable port, configures all three outputs. For each output the word holds a reference bypass, a choice between the two PLLs and a 5-bit post-divider. The processor and memory outputs can each borrow the other output's PLL. A strap input picks which of two reference tick inputs (40 MHz or 25 MHz) counts as the reference. A new setting is held in the control register and adopted by each output only at the end of one of its own divided periods, so no output ever emits a shortened period.

Top module: `clkgen_top`

## Requirements
- R1: With bypass clear, an output emits one tick for every (D+1) ticks of its selected source, where D is its 5-bit post-divider field; in steady state the gap between output ticks is (D+1) times the source period.
- R2: The post-divider fields sit at control bits 9:5 (processor), 14:10 (memory) and 19:15 (bus), and each field affects only its own output.
- R3: Control bits 2, 3 and 4 are the bypass flags for processor, memory and bus. A set flag makes that output tick once per reference tick, whatever its source-select bit and divider field hold.
- R4: The processor output divides the memory PLL when bit 21 is 1 and the processor PLL when it is 0.
- R5: The memory output divides the processor PLL when bit 20 is 1 and the memory PLL when it is 0.
- R6: The bus output divides the memory PLL when bit 24 is 1 and the processor PLL when it is 0.
- R7: Strap input `ref_is_40m` = 1 selects `ref40_tick` as the reference, and 0 selects `ref25_tick`.
- R8: A control write changes an output's source, bypass or divider only at one of that output's tick boundaries, so the period in progress completes at its old length.
- R9: Reset loads the control word 0x0000001C (all three bypass flags set, everything else zero), so every output starts at the reference rate.
- R10: A read returns the last value written with every bit outside {2-24 except 22 and 23} forced to zero, so the readable mask is 0x013FFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all ticks |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_is_40m | input | 1 | Strap: 1 selects the 40 MHz reference, 0 the 25 MHz reference |
| ref40_tick | input | 1 | Tick strobe of the 40 MHz reference |
| ref25_tick | input | 1 | Tick strobe of the 25 MHz reference |
| pll_cpu_tick | input | 1 | Tick strobe of the processor PLL |
| pll_mem_tick | input | 1 | Tick strobe of the memory PLL |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| cpu_tick | output | 1 | Divided processor clock enable |
| mem_tick | output | 1 | Divided memory clock enable |
| bus_tick | output | 1 | Divided bus clock enable |

## Verification
Each source runs at its own distinct rate: processor PLL every cycle, memory PLL every third cycle, 40 MHz reference every fifth and 25 MHz reference every seventh. The steady-state gap between output ticks therefore shows at once which source an output uses, whether it is bypassed, which reference the strap chose, and which divider applies. The control words cover zero dividers, mixed dividers, every cross-sourcing bit, partial and full bypass with junk in the ignored fields, and all-maximum dividers. Directed cases check the reset word and rate, masking of unassigned bits, and a divider change written mid-period, where the gap in progress must still run its old length of 32 before the new gap of 1.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

   localparam int CTRL_W     = 32;
   localparam int POST_DIV_W = 5;
   localparam int NUM_CH     = 3;

   localparam int CH_CPU = 0;
   localparam int CH_MEM = 1;
   localparam int CH_BUS = 2;

   // Bit positions that the channel decoding depends on.
   localparam int BYP_LSB          = 2;
   localparam int DIV_CPU_LSB      = 5;
   localparam int DIV_MEM_LSB      = 10;
   localparam int DIV_BUS_LSB      = 15;
   localparam int MEM_FROM_CPU_BIT = 20;
   localparam int CPU_FROM_MEM_BIT = 21;
   localparam int BUS_FROM_MEM_BIT = 24;

   localparam logic [CTRL_W-1:0] CTRL_MASK  = 32'h013F_FFFC;
   localparam logic [CTRL_W-1:0] CTRL_RESET = 32'h0000_001C;

   typedef struct packed {
      logic                  byp;
      logic                  use_mem_pll;
      logic [POST_DIV_W-1:0] div;
   } chan_cfg_t;

   function automatic chan_cfg_t decode_chan(input logic [CTRL_W-1:0] w, input int ch);
      chan_cfg_t c;
      c.byp = w[BYP_LSB + ch];
      case (ch)
         CH_CPU: begin
            c.use_mem_pll = w[CPU_FROM_MEM_BIT];
            c.div         = w[DIV_CPU_LSB +: POST_DIV_W];
         end
         CH_MEM: begin
            c.use_mem_pll = ~w[MEM_FROM_CPU_BIT];
            c.div         = w[DIV_MEM_LSB +: POST_DIV_W];
         end
         default: begin
            c.use_mem_pll = w[BUS_FROM_MEM_BIT];
            c.div         = w[DIV_BUS_LSB +: POST_DIV_W];
         end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/clkgen_ctrl_reg.sv
module clkgen_ctrl_reg #(
   parameter int               W        = 32,
   parameter logic [W-1:0]     MASK     = '1,
   parameter logic [W-1:0]     RST_VAL  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] q
);

   if ((RST_VAL & ~MASK) != '0) begin : g_bad_reset
      $error("clkgen_ctrl_reg: reset value sets bits outside the mask");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else if (wr_en) q <= wr_data & MASK;
   end

   assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~MASK) == '0);

endmodule

// File: rtl/clkgen_div_chan.sv
module clkgen_div_chan #(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_cpu,
   input  logic             src_mem,
   input  logic             src_ref,
   input  logic             nxt_byp,
   input  logic             nxt_use_mem,
   input  logic [DIV_W-1:0] nxt_div,
   output logic             out_tick
);

   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_width
      $error("clkgen_div_chan: DIV_W out of range");
   end

   logic             act_byp;
   logic             act_use_mem;
   logic [DIV_W-1:0] act_div;
   logic [DIV_W-1:0] cnt;
   logic             src;
   logic             wrap;

   always_comb begin
      if (act_byp)          src = src_ref;
      else if (act_use_mem) src = src_mem;
      else                  src = src_cpu;
      wrap = src && (act_byp || cnt == act_div);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_byp     <= 1'b1;
         act_use_mem <= 1'b0;
         act_div     <= '0;
         cnt         <= '0;
         out_tick    <= 1'b0;
      end else begin
         out_tick <= wrap;
         if (wrap) begin
            cnt         <= '0;
            act_byp     <= nxt_byp;
            act_use_mem <= nxt_use_mem;
            act_div     <= nxt_div;
         end else if (src) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= act_div);

   assert_out_from_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_tick |-> $past(src_cpu || src_mem || src_ref));

   assert_bypass_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act_byp && src_ref) |=> out_tick);

   assert_cfg_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({act_byp, act_use_mem, act_div}) |-> out_tick);

endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
   import clkgen_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_is_40m,
   input  logic              ref40_tick,
   input  logic              ref25_tick,
   input  logic              pll_cpu_tick,
   input  logic              pll_mem_tick,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output logic [CTRL_W-1:0] rd_data,
   output logic              cpu_tick,
   output logic              mem_tick,
   output logic              bus_tick
);

   logic              ref_tick;
   logic [NUM_CH-1:0] ticks;

   assign ref_tick = ref_is_40m ? ref40_tick : ref25_tick;

   clkgen_ctrl_reg #(
      .W       (CTRL_W),
      .MASK    (CTRL_MASK),
      .RST_VAL (CTRL_RESET)
   ) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .q       (rd_data)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      chan_cfg_t cfg;
      assign cfg = decode_chan(rd_data, g);

      clkgen_div_chan #(.DIV_W(POST_DIV_W)) chan_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .src_cpu     (pll_cpu_tick),
         .src_mem     (pll_mem_tick),
         .src_ref     (ref_tick),
         .nxt_byp     (cfg.byp),
         .nxt_use_mem (cfg.use_mem_pll),
         .nxt_div     (cfg.div),
         .out_tick    (ticks[g])
      );
   end

   assign cpu_tick = ticks[CH_CPU];
   assign mem_tick = ticks[CH_MEM];
   assign bus_tick = ticks[CH_BUS];

endmodule

// File: tb/clkgen_top_tb_top.sv
module clkgen_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_is_40m = 1'b1;
   logic        ref40_tick = 1'b0;
   logic        ref25_tick = 1'b0;
   logic        pll_cpu_tick = 1'b0;
   logic        pll_mem_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        cpu_tick, mem_tick, bus_tick;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   clkgen_top dut_i (
      .clk(clk), .rst_n(rst_n), .ref_is_40m(ref_is_40m),
      .ref40_tick(ref40_tick), .ref25_tick(ref25_tick),
      .pll_cpu_tick(pll_cpu_tick), .pll_mem_tick(pll_mem_tick),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .cpu_tick(cpu_tick), .mem_tick(mem_tick), .bus_tick(bus_tick)
   );

   // Source periods in cycles: cpu PLL 1, mem PLL 3, ref40 5, ref25 7.
   int ph3 = 0, ph5 = 0, ph7 = 0;
   always @(negedge clk) begin
      pll_cpu_tick <= 1'b1;
      pll_mem_tick <= (ph3 == 0);
      ref40_tick   <= (ph5 == 0);
      ref25_tick   <= (ph7 == 0);
      ph3 <= (ph3 == 2) ? 0 : ph3 + 1;
      ph5 <= (ph5 == 4) ? 0 : ph5 + 1;
      ph7 <= (ph7 == 6) ? 0 : ph7 + 1;
      cycles <= cycles + 1;
   end

   typedef struct packed {
      logic [31:0] word;
      logic        strap;
      logic [7:0]  p_cpu;
      logic [7:0]  p_mem;
      logic [7:0]  p_bus;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_0000, 1'b1, 8'd1,  8'd3,  8'd1 },  // R1 zero dividers
      '{32'h0002_0860, 1'b1, 8'd4,  8'd9,  8'd5 },  // R1 R2 mixed dividers
      '{32'h0130_1420, 1'b1, 8'd6,  8'd6,  8'd3 },  // R4 R5 R6 cross sources
      '{32'h0003_9CE4, 1'b1, 8'd5,  8'd24, 8'd8 },  // R3 cpu bypass, ref40
      '{32'h0020_03F8, 1'b0, 8'd96, 8'd7,  8'd7 },  // R3 R7 mem/bus bypass, ref25
      '{32'h013F_FFFC, 1'b0, 8'd7,  8'd7,  8'd7 },  // R3 all bypass, junk fields
      '{32'h010F_FFE0, 1'b1, 8'd32, 8'd96, 8'd96}   // R1 R6 max dividers
   };

   function automatic logic pick(input int ch);
      case (ch)
         0: return cpu_tick;
         1: return mem_tick;
         default: return bus_tick;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", req, act, act, exp, exp);
      end
   endtask

   task automatic write_ctrl(input logic [31:0] w);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Skip three ticks, then return the gap in cycles to the fourth.
   task automatic measure(input int ch, output int gap);
      int seen = 0;
      while (seen < 3) begin
         @(negedge clk);
         if (pick(ch)) seen++;
      end
      gap = 0;
      do begin
         @(negedge clk);
         gap++;
      end while (!pick(ch));
   endtask

   task automatic report;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      while (cycles < 150000 && !done) @(negedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         report();
      end
   end

   initial begin
      int g;
      repeat (4) @(negedge clk);
      // R9 reset word and quiet outputs during reset
      check(rd_data == 32'h0000_001C, "R9 reset word", rd_data, 32'h1C);
      check({cpu_tick, mem_tick, bus_tick} == 3'b000, "R9 outputs idle in reset",
            {cpu_tick, mem_tick, bus_tick}, 0);
      rst_n = 1'b1;
      measure(0, g); check(g == 5, "R9 cpu on reference after reset", g, 5);
      measure(2, g); check(g == 5, "R9 bus on reference after reset", g, 5);

      // R10 unassigned bits read back as zero
      write_ctrl(32'hFFFF_FFFF);
      @(negedge clk);
      check(rd_data == 32'h013F_FFFC, "R10 readback mask", rd_data, 32'h013F_FFFC);

      for (int i = 0; i < NV; i++) begin
         ref_is_40m = VECS[i].strap;
         write_ctrl(VECS[i].word);
         check(rd_data == VECS[i].word, "R10 readback", rd_data, VECS[i].word);
         measure(0, g); check(g == VECS[i].p_cpu, "R1 R3 R4 R7 cpu gap", g, VECS[i].p_cpu);
         measure(1, g); check(g == VECS[i].p_mem, "R1 R3 R5 R7 mem gap", g, VECS[i].p_mem);
         measure(2, g); check(g == VECS[i].p_bus, "R2 R3 R6 R7 bus gap", g, VECS[i].p_bus);
      end

      // R8: cpu divider 31 on cpu PLL, then switch to divider 0 mid-period
      ref_is_40m = 1'b1;
      write_ctrl(32'h0000_03E0);
      measure(0, g); check(g == 32, "R8 cpu old period", g, 32);
      while (!cpu_tick) @(negedge clk);
      g = 0;
      @(negedge clk); g++;
      wr_en = 1'b1; wr_data = 32'h0;
      @(negedge clk); g++;
      wr_en = 1'b0;
      while (!cpu_tick) begin
         @(negedge clk);
         g++;
      end
      check(g == 32, "R8 period in progress keeps old length", g, 32);
      @(negedge clk);
      check(cpu_tick == 1'b1, "R8 new divider after boundary", cpu_tick, 1);

      done = 1'b1;
      report();
   end

endmodule